// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

The block is an 8-bit preloadable down counter that counts a slow tick of roughly 100 µs. A parameterised prescaler divides the system clock to make that tick. Software writes one control word. That word sets the reload value, picks manual or automatic restart, and starts or stops the count. Each time the count runs out, the block emits a one-cycle expiry strobe, which other blocks can use to latch data. The same expiry also sets bit 0 of a small status register.

The status register also collects events from other sources through generic set inputs. Software clears status bits by writing ones to them. An enable register masks the status bits onto one level-sensitive interrupt line. An interrupt handler can write zero to the enable register to drop the line. Events that arrive while the line is masked stay pending, and the line rises again as soon as the enable value is restored.

Top module: `interval_irq_timer`

## Requirements
- R1: After reset the timer is stopped, the reload value is 0, and the status bits, enable bits, `irq_o` and `expire_o` are all 0.
- R2: A control write with bit 1 = 0 and bit 0 = 1 loads the reload value from bits [15:8] and starts manual mode. `expire_o` rises PRESCALE × reload clock cycles after the write edge. The timer then stops, with no further expiry.
- R3: A control write with bit 1 = 1 starts auto mode whatever the value of bit 0. Expiry then repeats every PRESCALE × reload cycles, counted from the write edge, until the next control write.
- R4: A control write with bits [1:0] = 00 stops a running timer, so no expiry follows. A start with a reload value of 0 never expires.
- R5: Each expiry drives `expire_o` high for exactly one cycle. On the edge after the strobe, status bit 0 is set.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both 1. It follows an enable write on the next cycle, so restoring the enable bits re-raises the line for a pending bit.
- R7: A status write clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: A pulse on `ext_set_i[k]` sets status bit k (k ≥ 1). This happens even while the interrupt is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 16 | Control word: [15:8] reload, [1] auto mode, [0] start |
| stat_we_i | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata_i | input | NSRC | Status bits to clear |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NSRC | New enable bits |
| ext_set_i | input | NSRC-1 | Set pulses for status bits NSRC-1..1 |
| status_o | output | NSRC | Status register |
| enable_o | output | NSRC | Enable register |
| irq_o | output | 1 | Level interrupt line |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
Assertions inside the RTL check the following on every cycle:
- The expiry strobe never lasts two cycles.
- A manual expiry leaves the timer stopped.
- An auto expiry reloads the count.
- Set events win over clears.
- Written-one bits clear and unwritten bits hold.
- The line stays low while all enables are zero.

Only the bench scenarios can show the exact expiry cycle for each reload value and mode, including the boundary reload values 1 and 255. The same applies to the absence of any expiry after a stop or after a zero reload. The same also applies to the re-raise of the line when a masked pending event has its enable restored.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned RELOAD_LSB = 8;
  localparam int unsigned MODE_BIT  = 1;
  localparam int unsigned START_BIT = 0;

  typedef struct packed {
    logic [7:0] reload;
    logic       auto_mode;
    logic       go;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.reload    = w[RELOAD_LSB +: 8];
    c.auto_mode = w[MODE_BIT];
    c.go        = w[MODE_BIT] | w[START_BIT];
    return c;
  endfunction
endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
  parameter int unsigned PRESCALE = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clr_i || !run_i)   div_q <= '0;
    else if (div_q == LAST)     div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && !clr_i && (div_q == LAST);
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              tick_i,
  output logic              running_o,
  output logic              expire_o
);
  ctrl_t            cfg;
  logic [CNT_W-1:0] reload_q, count_q;
  logic             auto_q, running_q, expire_q;
  logic             last_tick;

  assign cfg       = decode_ctrl(ctrl_wdata_i);
  assign last_tick = tick_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q  <= '0;
      count_q   <= '0;
      auto_q    <= 1'b0;
      running_q <= 1'b0;
      expire_q  <= 1'b0;
    end else begin
      expire_q <= !ctrl_we_i && last_tick;
      if (ctrl_we_i) begin
        reload_q  <= CNT_W'(cfg.reload);
        auto_q    <= cfg.auto_mode;
        running_q <= cfg.go && (cfg.reload != '0);
        count_q   <= CNT_W'(cfg.reload);
      end else if (last_tick) begin
        if (auto_q) begin
          count_q <= reload_q;
        end else begin
          running_q <= 1'b0;
          count_q   <= '0;
        end
      end else if (tick_i) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign running_o = running_q;
  assign expire_o  = expire_q;

  p_strobe_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |=> !expire_q);
  p_manual_stops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_q && !auto_q) |-> !running_q);
  p_auto_reloads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_q && auto_q) |-> (running_q && count_q == reload_q));
  p_stop_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[1:0] == 2'b00) |=> (!running_q && !expire_q));
endmodule

// File: rtl/itmr_irq_ctrl.sv
module itmr_irq_ctrl #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            stat_we_i,
  input  logic [NSRC-1:0] stat_wdata_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] enable_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status_q, enable_q, clr;

  assign clr = stat_we_i ? stat_wdata_i : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_q[i] <= 1'b0;
      else if (set_i[i]) status_q[i] <= 1'b1;
      else if (clr[i])   status_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enable_q <= '0;
    else if (en_we_i) enable_q <= en_wdata_i;
  end

  assign irq_o    = |(status_q & enable_q);
  assign status_o = status_q;
  assign enable_o = enable_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  p_w1c_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> ((status_q & $past(stat_wdata_i & ~set_i)) == '0));
  p_hold_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_masked_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q == '0) |-> !irq_o);
endmodule

// File: rtl/interval_irq_timer.sv
module interval_irq_timer
  import itmr_pkg::*;
#(
  parameter int unsigned PRESCALE = 25000,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned NSRC     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              stat_we_i,
  input  logic [NSRC-1:0]   stat_wdata_i,
  input  logic              en_we_i,
  input  logic [NSRC-1:0]   en_wdata_i,
  input  logic [NSRC-1:1]   ext_set_i,
  output logic [NSRC-1:0]   status_o,
  output logic [NSRC-1:0]   enable_o,
  output logic              irq_o,
  output logic              expire_o
);
  logic tick, running, expire;

  itmr_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_we_i),
    .run_i  (running),
    .tick_o (tick)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .tick_i       (tick),
    .running_o    (running),
    .expire_o     (expire)
  );

  itmr_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        ({ext_set_i, expire}),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .en_we_i      (en_we_i),
    .en_wdata_i   (en_wdata_i),
    .status_o     (status_o),
    .enable_o     (enable_o),
    .irq_o        (irq_o)
  );

  assign expire_o = expire;

  p_status_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> status_o[0]);
endmodule

// File: tb/interval_irq_timer_tb.sv
`timescale 1ns/1ps
module interval_irq_timer_tb;
  localparam int P = 4;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, stat_we = 0, en_we = 0;
  logic [15:0] ctrl_wd = '0;
  logic [N-1:0] stat_wd = '0, en_wd = '0;
  logic [N-1:1] ext_set = '0;
  logic [N-1:0] status, enable;
  logic irq, expire;

  int cyc = 0, checks = 0, errors = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_irq_timer #(.PRESCALE(P), .CNT_W(8), .NSRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd), .en_we_i(en_we),
    .en_wdata_i(en_wd), .ext_set_i(ext_set), .status_o(status),
    .enable_o(enable), .irq_o(irq), .expire_o(expire));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected expiry cycles
  always @(negedge clk) if (rst_n && expire) begin
    if (exp_q.size() == 0) check("R4/R2 unexpected expiry at cycle", cyc, -1);
    else check("R2/R3/R5 expiry cycle", cyc, exp_q.pop_front());
  end

  task automatic wr_ctrl(input logic [15:0] d);
    @(negedge clk); ctrl_we = 1; ctrl_wd = d;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_en(input logic [N-1:0] d);
    @(negedge clk); en_we = 1; en_wd = d;
    @(negedge clk); en_we = 0;
  endtask
  task automatic wr_stat(input logic [N-1:0] d);
    @(negedge clk); stat_we = 1; stat_wd = d;
    @(negedge clk); stat_we = 0;
  endtask
  task automatic pulse_set(input logic [N-1:1] d);
    @(negedge clk); ext_set = d;
    @(negedge clk); ext_set = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  // driver: start and queue expected expiries
  task automatic start(input logic [15:0] d, input int count);
    int c0;
    wr_ctrl(d);
    c0 = cyc;
    for (int k = 1; k <= count; k++) exp_q.push_back(c0 + k * int'(d[15:8]) * P);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check("R1 status", int'(status), 0);
    check("R1 enable", int'(enable), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 expire", int'(expire), 0);
    idle(20);
    check("R1 no expiry while stopped", exp_q.size(), 0);

    // R2 manual, reload 3
    start(16'h0301, 1);
    idle(40);
    check("R2 queue drained, stopped", exp_q.size(), 0);
    check("R5 status bit0 set", int'(status), 1);
    check("R6 masked irq low", int'(irq), 0);

    // R6 enable, mask, pending re-raise
    wr_en(4'b0001);
    check("R6 irq high on enable", int'(irq), 1);
    wr_en(4'b0000);
    check("R6 irq low on zero enable", int'(irq), 0);
    pulse_set(3'b010);
    check("R9 ext bit2 set while masked", int'(status), 5);
    check("R6 still low while masked", int'(irq), 0);
    wr_en(4'b0100);
    check("R6 irq re-raised on restore", int'(irq), 1);

    // R7 write-one-to-clear
    wr_stat(4'b0001);
    check("R7 clear bit0 only", int'(status), 4);
    wr_stat(4'b0000);
    check("R7 zero write keeps bits", int'(status), 4);

    // R8 set beats clear
    @(negedge clk); ext_set = 3'b001; stat_we = 1; stat_wd = 4'b0010;
    @(negedge clk); ext_set = '0; stat_we = 0;
    check("R8 set wins over clear", int'(status), 6);
    wr_stat(4'b1111);
    check("R7 clear all", int'(status), 0);
    check("R6 irq low after clear", int'(irq), 0);

    // R3 auto, start bit 0 (no effect of bit0)
    start(16'h0202, 3);
    idle(26);
    wr_ctrl(16'h0000);
    idle(40);
    check("R3 auto three expiries then stop", exp_q.size(), 0);
    start(16'h0203, 2);
    idle(18);
    wr_ctrl(16'h0000);
    idle(40);
    check("R3 auto with bit0 same period", exp_q.size(), 0);
    wr_stat(4'b1111);

    // R4 stop mid-run and zero reload
    wr_ctrl(16'h0501);
    idle(8);
    wr_ctrl(16'h0000);
    idle(40);
    check("R4 stopped run no status", int'(status), 0);
    wr_ctrl(16'h0001);
    idle(30);
    check("R4 zero reload no status", int'(status), 0);
    wr_ctrl(16'h0002);
    idle(30);
    check("R4 zero reload auto no status", int'(status), 0);

    // boundaries
    start(16'h0101, 1);
    idle(10);
    check("R2 reload 1 expiry", exp_q.size(), 0);
    start(16'hFF01, 1);
    idle(255 * P + 10);
    check("R2 reload 255 expiry", exp_q.size(), 0);
    check("R5 status after 255", int'(status), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule